// File: doc/BRIEF.md
# Four-Channel Rotating Burst Copy Engine

The block copies memory to memory for four independent channels. Each channel holds a source pointer, a destination pointer, a byte count and a run flag. Software fills in the pointers and count through a simple register write port and then sets the run flag. The engine is paced by an external service tick. Each accepted tick serves exactly one channel, taken in rotating order. During that service the engine copies at most one burst of 2048 bytes, word by word, over a synchronous memory port. When a channel is found running with nothing left to copy, its run flag drops and a completion flag is raised. A per-channel fault counter can force an error abort instead. Completion and error flags are write-1-to-clear, and their OR drives a single interrupt line.

Service is sequenced by a state machine:
- SV_IDLE goes to SV_CHECK on a tick and ignores ticks in every other state.
- SV_CHECK goes to SV_FINISH when the channel is stopped, when the fault counter expires, or when the count is zero. Otherwise it goes to SV_READ.
- SV_READ issues a word read and always goes to SV_WRITE.
- SV_WRITE writes the word returned one cycle after the read. It goes back to SV_READ while burst bytes remain, and to SV_FINISH on the last word.
- SV_FINISH pulses the tick-done output, moves to the next channel and returns to SV_IDLE.

Top module: `qdma_top`

## Requirements
- R1: After reset all run flags, completion flags and error flags are 0, `irq`, `tick_done` and `mem_req` are 0, and all pointers, counts and fault counters read as 0.
- R2: Register writes use field codes 0 for source, 1 for destination, 2 for count and 3 for control. A pointer write drops bits 1:0. A count write keeps only bits 12:0, so the largest count is 0x1FFF.
- R3: A control write loads the run flag from data bit 31, so it can start or clear a channel. The `busy` bit of a channel is its run flag. A control read returns the run flag in bit 31 and the fault counter in the low bits.
- R4: A tick that is accepted in SV_IDLE serves one channel, in the order 0, 1, 2, 3, 0 and so on. The service ends with a one-cycle `tick_done` pulse. Ticks that arrive during a service are ignored.
- R5: A service on a running channel with a nonzero count and no fault expiry moves min(count, 0x800) bytes. Both pointers advance by that number and the count drops by it.
- R6: Each word is read and then written on the next cycle, using the read data, which arrives with one-cycle latency. A final partial word of k bytes (k<4) writes with byte enables set on the low k lanes only.
- R7: A running channel with count 0 at service time clears its run flag and sets completion bit N for channel N.
- R8: A nonzero fault counter decrements on each service of a running channel. When it reaches 0, the run flag clears, error bit N is set, and no data moves and no pointer or count changes.
- R9: A stop command clears the run flag of the chosen channel on the next clock. Later services of that channel move nothing.
- R10: Writing 1 to a bit of `done_clr` or `err_clr` clears that flag. Flags not cleared hold their value. A flag set by the engine in the same cycle as a clear stays set.
- R11: `irq` is high exactly when any completion or error flag is set.
- R12: A new completion or error flag appears only in the cycle `tick_done` is high, and at most one new flag appears per service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | 2 | Channel for register write |
| reg_field | input | 2 | Field code for register write |
| reg_wdata | input | 32 | Register write data |
| rd_ch | input | 2 | Channel for register read |
| rd_field | input | 2 | Field code for register read |
| rd_data | output | 32 | Combinational register read data |
| fail_we | input | 1 | Load fault counter strobe |
| fail_ch | input | 2 | Channel for fault counter load |
| fail_val | input | 4 | Fault counter load value |
| stop_valid | input | 1 | Stop command strobe |
| stop_ch | input | 2 | Channel to stop |
| done_clr | input | 4 | Write-1-to-clear for completion flags |
| err_clr | input | 4 | Write-1-to-clear for error flags |
| tick | input | 1 | Service tick request |
| tick_done | output | 1 | One-cycle pulse at the end of a service |
| busy | output | 4 | Run flag per channel |
| done_flags | output | 4 | Completion flags |
| err_flags | output | 4 | Error flags |
| irq | output | 1 | OR of all completion and error flags |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after the read |

## Verification
The assertions assume that memory returns read data exactly one cycle after a read request. The stimulus meets this with a memory model that registers read data on the same edge that samples the request. The stop check further assumes that no control write targets the stopped channel in the same cycle, and the checker's antecedent excludes that case. The assertions also assume that software does not rewrite the pointers or count of the channel being served while its service is in progress. The stimulus honours this by making all register writes, stops and fault loads only between services, after `tick_done` has returned low.

// File: rtl/qdma_pkg.sv
package qdma_pkg;

    typedef enum logic [1:0] {
        FLD_SRC  = 2'd0,
        FLD_DST  = 2'd1,
        FLD_CNT  = 2'd2,
        FLD_CTRL = 2'd3
    } fld_e;

    typedef enum logic [2:0] {
        SV_IDLE,
        SV_CHECK,
        SV_READ,
        SV_WRITE,
        SV_FINISH
    } svc_e;

    localparam int RUN_BIT = 31;

endpackage

// File: rtl/qdma_chan_regs.sv
module qdma_chan_regs
    import qdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 13,
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_we,
    input  logic [1:0]    sw_field,
    input  logic [31:0]   sw_wdata,
    input  logic          stop,
    input  logic          fail_we,
    input  logic [FW-1:0] fail_val,
    input  logic          eng_upd,
    input  logic [AW-1:0] eng_src,
    input  logic [AW-1:0] eng_dst,
    input  logic [CW-1:0] eng_cnt,
    input  logic          eng_clr_run,
    input  logic          eng_dec_fail,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [CW-1:0] cnt,
    output logic          run,
    output logic [FW-1:0] fail
);

    logic ctrl_wr;
    assign ctrl_wr = sw_we && (sw_field == FLD_CTRL);

    // pointers and count: the engine's write-back wins over software
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src <= '0;
            dst <= '0;
            cnt <= '0;
        end else if (eng_upd) begin
            src <= eng_src;
            dst <= eng_dst;
            cnt <= eng_cnt;
        end else if (sw_we) begin
            case (fld_e'(sw_field))
                FLD_SRC: src <= {sw_wdata[AW-1:2], 2'b00};
                FLD_DST: dst <= {sw_wdata[AW-1:2], 2'b00};
                FLD_CNT: cnt <= sw_wdata[CW-1:0];
                default: ;
            endcase
        end
    end

    // run flag: stop beats a control write, which beats an engine clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= 1'b0;
        end else if (stop) begin
            run <= 1'b0;
        end else if (ctrl_wr) begin
            run <= sw_wdata[RUN_BIT];
        end else if (eng_clr_run) begin
            run <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail <= '0;
        end else if (fail_we) begin
            fail <= fail_val;
        end else if (eng_dec_fail) begin
            fail <= fail - FW'(1);
        end
    end

endmodule

// File: rtl/qdma_flag_bank.sv
module qdma_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);

    // a set in the same cycle as a clear leaves the flag high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr) | set;
        end
    end

endmodule

// File: rtl/qdma_svc_fsm.sv
module qdma_svc_fsm
    import qdma_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int AW    = 32,
    parameter int CW    = 13,
    parameter int FW    = 4,
    parameter int BURST = 2048,
    localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [AW-1:0]  cv_src,
    input  logic [AW-1:0]  cv_dst,
    input  logic [CW-1:0]  cv_cnt,
    input  logic           cv_run,
    input  logic [FW-1:0]  cv_fail,
    input  logic [31:0]    mem_rdata,
    output logic [CHW-1:0] cur_ch,
    output logic           eng_upd,
    output logic [AW-1:0]  eng_src,
    output logic [AW-1:0]  eng_dst,
    output logic [CW-1:0]  eng_cnt,
    output logic           eng_clr_run,
    output logic           eng_dec_fail,
    output logic [NCH-1:0] set_done,
    output logic [NCH-1:0] set_err,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [3:0]     mem_be,
    output logic [31:0]    mem_wdata,
    output logic           tick_done
);

    localparam logic [CW-1:0] BURST_V = CW'(BURST);

    svc_e          state;
    svc_e          nstate;
    logic [AW-1:0] w_src;
    logic [AW-1:0] w_dst;
    logic [CW-1:0] w_cnt;
    logic [CW-1:0] left;
    logic [2:0]    step;
    logic          fail_hit;

    assign step     = (left < CW'(4)) ? left[2:0] : 3'd4;
    assign fail_hit = (cv_fail == FW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SV_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // transitions
    always_comb begin
        nstate = state;
        unique case (state)
            SV_IDLE:   if (tick) nstate = SV_CHECK;
            SV_CHECK: begin
                if (!cv_run || fail_hit || (cv_cnt == '0)) begin
                    nstate = SV_FINISH;
                end else begin
                    nstate = SV_READ;
                end
            end
            SV_READ:   nstate = SV_WRITE;
            SV_WRITE:  nstate = (left == CW'(step)) ? SV_FINISH : SV_READ;
            SV_FINISH: nstate = SV_IDLE;
            default:   nstate = SV_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        eng_upd      = 1'b0;
        eng_src      = w_src + AW'(step);
        eng_dst      = w_dst + AW'(step);
        eng_cnt      = w_cnt - CW'(step);
        eng_clr_run  = 1'b0;
        eng_dec_fail = 1'b0;
        set_done     = '0;
        set_err      = '0;
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_addr     = '0;
        mem_be       = 4'h0;
        mem_wdata    = '0;
        tick_done    = 1'b0;
        unique case (state)
            SV_IDLE: ;
            SV_CHECK: begin
                if (cv_run) begin
                    eng_dec_fail = (cv_fail != '0);
                    if (fail_hit) begin
                        eng_clr_run     = 1'b1;
                        set_err[cur_ch] = 1'b1;
                    end else if (cv_cnt == '0) begin
                        eng_clr_run      = 1'b1;
                        set_done[cur_ch] = 1'b1;
                    end
                end
            end
            SV_READ: begin
                mem_req  = 1'b1;
                mem_addr = {w_src[AW-1:2], 2'b00};
            end
            SV_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {w_dst[AW-1:2], 2'b00};
                mem_wdata = mem_rdata;
                mem_be    = 4'((5'd1 << step) - 5'd1);
                eng_upd   = 1'b1;
            end
            SV_FINISH: tick_done = 1'b1;
            default: ;
        endcase
    end

    // working copy of the channel under service and the rotation pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_src  <= '0;
            w_dst  <= '0;
            w_cnt  <= '0;
            left   <= '0;
            cur_ch <= '0;
        end else begin
            case (state)
                SV_CHECK: begin
                    w_src <= cv_src;
                    w_dst <= cv_dst;
                    w_cnt <= cv_cnt;
                    left  <= (cv_cnt > BURST_V) ? BURST_V : cv_cnt;
                end
                SV_WRITE: begin
                    w_src <= eng_src;
                    w_dst <= eng_dst;
                    w_cnt <= eng_cnt;
                    left  <= left - CW'(step);
                end
                SV_FINISH: begin
                    if (cur_ch == CHW'(NCH - 1)) begin
                        cur_ch <= '0;
                    end else begin
                        cur_ch <= cur_ch + CHW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/qdma_top.sv
module qdma_top
    import qdma_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int AW    = 32,
    parameter int CW    = 13,
    parameter int FW    = 4,
    parameter int BURST = 2048,
    localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [CHW-1:0] reg_ch,
    input  logic [1:0]     reg_field,
    input  logic [31:0]    reg_wdata,
    input  logic [CHW-1:0] rd_ch,
    input  logic [1:0]     rd_field,
    output logic [31:0]    rd_data,
    input  logic           fail_we,
    input  logic [CHW-1:0] fail_ch,
    input  logic [FW-1:0]  fail_val,
    input  logic           stop_valid,
    input  logic [CHW-1:0] stop_ch,
    input  logic [NCH-1:0] done_clr,
    input  logic [NCH-1:0] err_clr,
    input  logic           tick,
    output logic           tick_done,
    output logic [NCH-1:0] busy,
    output logic [NCH-1:0] done_flags,
    output logic [NCH-1:0] err_flags,
    output logic           irq,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [3:0]     mem_be,
    output logic [31:0]    mem_wdata,
    input  logic [31:0]    mem_rdata
);

    logic [AW-1:0]  src_a  [NCH];
    logic [AW-1:0]  dst_a  [NCH];
    logic [CW-1:0]  cnt_a  [NCH];
    logic [FW-1:0]  fail_a [NCH];
    logic [NCH-1:0] run_v;

    logic [CHW-1:0] cur_ch;
    logic           eng_upd;
    logic [AW-1:0]  eng_src;
    logic [AW-1:0]  eng_dst;
    logic [CW-1:0]  eng_cnt;
    logic           eng_clr_run;
    logic           eng_dec_fail;
    logic [NCH-1:0] set_done;
    logic [NCH-1:0] set_err;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        logic sel;
        assign sel = (cur_ch == CHW'(i));
        qdma_chan_regs #(.AW(AW), .CW(CW), .FW(FW)) u_regs (
            .clk          (clk),
            .rst_n        (rst_n),
            .sw_we        (reg_we && (reg_ch == CHW'(i))),
            .sw_field     (reg_field),
            .sw_wdata     (reg_wdata),
            .stop         (stop_valid && (stop_ch == CHW'(i))),
            .fail_we      (fail_we && (fail_ch == CHW'(i))),
            .fail_val     (fail_val),
            .eng_upd      (eng_upd && sel),
            .eng_src      (eng_src),
            .eng_dst      (eng_dst),
            .eng_cnt      (eng_cnt),
            .eng_clr_run  (eng_clr_run && sel),
            .eng_dec_fail (eng_dec_fail && sel),
            .src          (src_a[i]),
            .dst          (dst_a[i]),
            .cnt          (cnt_a[i]),
            .run          (run_v[i]),
            .fail         (fail_a[i])
        );
    end

    qdma_svc_fsm #(
        .NCH(NCH), .AW(AW), .CW(CW), .FW(FW), .BURST(BURST)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .cv_src       (src_a[cur_ch]),
        .cv_dst       (dst_a[cur_ch]),
        .cv_cnt       (cnt_a[cur_ch]),
        .cv_run       (run_v[cur_ch]),
        .cv_fail      (fail_a[cur_ch]),
        .mem_rdata    (mem_rdata),
        .cur_ch       (cur_ch),
        .eng_upd      (eng_upd),
        .eng_src      (eng_src),
        .eng_dst      (eng_dst),
        .eng_cnt      (eng_cnt),
        .eng_clr_run  (eng_clr_run),
        .eng_dec_fail (eng_dec_fail),
        .set_done     (set_done),
        .set_err      (set_err),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_be       (mem_be),
        .mem_wdata    (mem_wdata),
        .tick_done    (tick_done)
    );

    qdma_flag_bank #(.N(NCH)) u_done (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_done),
        .clr   (done_clr),
        .flags (done_flags)
    );

    qdma_flag_bank #(.N(NCH)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_err),
        .clr   (err_clr),
        .flags (err_flags)
    );

    assign busy = run_v;
    assign irq  = |{done_flags, err_flags};

    always_comb begin
        rd_data = '0;
        case (fld_e'(rd_field))
            FLD_SRC: rd_data = 32'(src_a[rd_ch]);
            FLD_DST: rd_data = 32'(dst_a[rd_ch]);
            FLD_CNT: rd_data = 32'(cnt_a[rd_ch]);
            default: begin
                rd_data[RUN_BIT] = run_v[rd_ch];
                rd_data[FW-1:0]  = fail_a[rd_ch];
            end
        endcase
    end

endmodule

// File: rtl/qdma_chk.sv
module qdma_chk #(
    parameter int NCH = 4,
    parameter int CHW = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           reg_we,
    input logic [CHW-1:0] reg_ch,
    input logic [1:0]     reg_field,
    input logic           stop_valid,
    input logic [CHW-1:0] stop_ch,
    input logic [NCH-1:0] done_clr,
    input logic           tick_done,
    input logic [NCH-1:0] busy,
    input logic [NCH-1:0] done_flags,
    input logic [NCH-1:0] err_flags,
    input logic           mem_req,
    input logic           mem_we,
    input logic [3:0]     mem_be
);

    // R4
    tick_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_done |=> !tick_done);

    // R6
    write_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> $past(mem_req && !mem_we));

    // R6
    write_has_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_be != 4'h0));

    // R12
    flag_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((done_flags | err_flags) & ~$past(done_flags | err_flags)) != '0) |-> tick_done);

    // R12
    one_flag_per_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones((done_flags | err_flags) & ~$past(done_flags | err_flags)) <= 1);

    // R10
    uncleared_flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((done_flags & $past(done_flags & ~done_clr)) == $past(done_flags & ~done_clr)));

    // R9
    stop_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_valid && !(reg_we && reg_field == 2'd3 && reg_ch == stop_ch))
        |=> (busy[$past(stop_ch)] == 1'b0));

    // R3
    run_rises_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((busy & ~$past(busy)) != '0) |-> $past(reg_we && reg_field == 2'd3));

endmodule

bind qdma_top qdma_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_ch     (reg_ch),
    .reg_field  (reg_field),
    .stop_valid (stop_valid),
    .stop_ch    (stop_ch),
    .done_clr   (done_clr),
    .tick_done  (tick_done),
    .busy       (busy),
    .done_flags (done_flags),
    .err_flags  (err_flags),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_be     (mem_be)
);

// File: tb/sim_qdma_top.sv
module sim_qdma_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_ch = '0;
    logic [1:0]  reg_field = '0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  rd_ch = '0;
    logic [1:0]  rd_field = '0;
    logic [31:0] rd_data;
    logic        fail_we = 1'b0;
    logic [1:0]  fail_ch = '0;
    logic [3:0]  fail_val = '0;
    logic        stop_valid = 1'b0;
    logic [1:0]  stop_ch = '0;
    logic [3:0]  done_clr = '0;
    logic [3:0]  err_clr = '0;
    logic        tick = 1'b0;
    logic        tick_done;
    logic [3:0]  busy;
    logic [3:0]  done_flags;
    logic [3:0]  err_flags;
    logic        irq;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int bad = 0;

    always #2 clk = ~clk;

    qdma_top u0 (.*);

    // memory model: 32 KB, one-cycle read latency
    logic [31:0] mem [8192];
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[14:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[14:2]];
            end
        end
    end

    function automatic logic [31:0] pat(input int byte_addr);
        return 32'h5A5A_0000 ^ ((byte_addr >> 2) * 32'h0001_0103);
    endfunction

    // reference model of channel state
    int   m_src [4];
    int   m_dst [4];
    int   m_cnt [4];
    int   m_fail[4];
    logic [3:0] m_run  = '0;
    logic [3:0] m_done = '0;
    logic [3:0] m_err  = '0;
    int   m_cur = 0;

    logic [11:0] exp_q[$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: one expected status item per service
    always @(negedge clk) begin
        if (rst_n && tick_done) begin
            if (exp_q.size() == 0) begin
                checks++;
                bad++;
                $display("FAIL R4 unexpected tick_done act=1 exp=0");
            end else begin
                logic [11:0] e;
                e = exp_q.pop_front();
                check("R4/R5/R7/R8/R12 status after service",
                      32'({done_flags, err_flags, busy}), 32'(e));
            end
        end
    end

    task automatic model_tick(input logic [3:0] clr);
        int c;
        int n;
        logic hit;
        logic [3:0] set;
        c = m_cur;
        set = '0;
        hit = 1'b0;
        if (m_run[c]) begin
            if (m_fail[c] > 0) begin
                m_fail[c]--;
                if (m_fail[c] == 0) begin
                    m_run[c] = 1'b0;
                    m_err[c] = 1'b1;
                    hit = 1'b1;
                end
            end
            if (!hit) begin
                if (m_cnt[c] == 0) begin
                    m_run[c] = 1'b0;
                    set[c] = 1'b1;
                end else begin
                    n = (m_cnt[c] > 2048) ? 2048 : m_cnt[c];
                    m_cnt[c] -= n;
                    m_src[c] += n;
                    m_dst[c] += n;
                end
            end
        end
        m_done = (m_done & ~clr) | set;
        m_cur = (c + 1) % 4;
        exp_q.push_back({m_done, m_err, m_run});
    endtask

    // mode 0: plain, 1: extra tick during service, 2: clear done of served channel in its check cycle
    task automatic do_tick(input int mode);
        logic [3:0] clr;
        clr = (mode == 2) ? 4'(1 << m_cur) : 4'h0;
        model_tick(clr);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) begin
            tick = 1'b0;
            done_clr = clr;
        end
        @(negedge clk) done_clr = '0;
        if (mode == 1) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
        while (!tick_done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int ch, input int fld, input logic [31:0] d);
        @(negedge clk) begin
            reg_we = 1'b1;
            reg_ch = 2'(ch);
            reg_field = 2'(fld);
            reg_wdata = d;
        end
        @(negedge clk) reg_we = 1'b0;
        case (fld)
            0: m_src[ch] = int'(d & 32'hFFFF_FFFC);
            1: m_dst[ch] = int'(d & 32'hFFFF_FFFC);
            2: m_cnt[ch] = int'(d & 32'h1FFF);
            default: m_run[ch] = d[31];
        endcase
    endtask

    task automatic set_fail(input int ch, input int v);
        @(negedge clk) begin
            fail_we = 1'b1;
            fail_ch = 2'(ch);
            fail_val = 4'(v);
        end
        @(negedge clk) fail_we = 1'b0;
        m_fail[ch] = v;
    endtask

    task automatic rd(input int ch, input int fld, output logic [31:0] d);
        @(negedge clk) begin
            rd_ch = 2'(ch);
            rd_field = 2'(fld);
        end
        #1 d = rd_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 8192; i++) mem[i] = pat(i * 4);
        for (int i = 0; i < 4; i++) begin
            m_src[i] = 0; m_dst[i] = 0; m_cnt[i] = 0; m_fail[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", 32'(busy), 32'h0);
        check("R1 done", 32'(done_flags), 32'h0);
        check("R1 err", 32'(err_flags), 32'h0);
        check("R1 irq/tick_done/mem_req", 32'({irq, tick_done, mem_req}), 32'h0);
        rd(0, 2, d); check("R1 count", d, 32'h0);
        rd(3, 3, d); check("R1 control", d, 32'h0);

        wr(0, 0, 32'h0100); wr(0, 1, 32'h0400); wr(0, 2, 32'h0010);
        wr(1, 0, 32'h1003); wr(1, 1, 32'h4000); wr(1, 2, 32'h3005);
        rd(1, 0, d); check("R2 source low bits dropped", d, 32'h1000);
        rd(1, 2, d); check("R2 count kept to 13 bits", d, 32'h1005);
        wr(2, 0, 32'h6000); wr(2, 1, 32'h6800); wr(2, 2, 32'h0008);
        set_fail(2, 1);
        wr(3, 0, 32'h6100); wr(3, 1, 32'h7000); wr(3, 2, 32'h1000);
        set_fail(3, 2);
        for (int i = 0; i < 4; i++) wr(i, 3, 32'h8000_0000);
        @(negedge clk);
        check("R3 run set by control write", 32'(busy), 32'hF);
        rd(3, 3, d); check("R3 control readback", d, 32'h8000_0002);

        do_tick(0);                               // ch0: 16 bytes
        do_tick(0);                               // ch1: first burst
        rd(1, 2, d); check("R5 count after burst", d, 32'h0805);
        rd(1, 0, d); check("R5 source after burst", d, 32'h1800);
        rd(1, 1, d); check("R5 destination after burst", d, 32'h4800);
        do_tick(0);                               // ch2: fault expires
        rd(2, 2, d); check("R8 count untouched on fault", d, 32'h0008);
        check("R8 no data moved", mem[32'h6800 >> 2], pat(32'h6800));
        do_tick(0);                               // ch3: fault 2->1, burst moves

        @(negedge clk) begin stop_valid = 1'b1; stop_ch = 2'd3; end
        @(negedge clk) stop_valid = 1'b0;
        m_run[3] = 1'b0;
        check("R9 stop clears run", 32'(busy[3]), 32'h0);

        do_tick(2);                               // ch0: completes while clear pulses (R10)
        do_tick(1);                               // ch1: second burst, extra tick ignored (R4)
        for (int t = 0; t < 8; t++) do_tick(0);   // ch1 partial tail, then completion

        check("R4 every service matched", 32'(exp_q.size()), 32'h0);
        check("R7 done flags", 32'(done_flags), 32'h3);
        check("R8 error flags", 32'(err_flags), 32'h4);
        check("R11 irq with flags", 32'(irq), 32'h1);
        for (int w = 0; w < 4; w++)
            check("R5 ch0 copy", mem[(32'h0400 >> 2) + w], pat(32'h0100 + 4 * w));
        check("R5 ch1 first word", mem[32'h4000 >> 2], pat(32'h1000));
        check("R5 ch1 burst edge", mem[32'h4800 >> 2], pat(32'h1800));
        check("R5 ch1 last full word", mem[32'h5000 >> 2], pat(32'h2000));
        check("R6 partial word low lane only", mem[32'h5004 >> 2],
              (pat(32'h5004) & 32'hFFFF_FF00) | (pat(32'h2004) & 32'h0000_00FF));
        check("R6 beyond tail untouched", mem[32'h5008 >> 2], pat(32'h5008));
        rd(1, 2, d); check("R7 count ends at zero", d, 32'h0);
        check("R9 copied before stop", mem[32'h77FC >> 2], pat(32'h68FC));
        check("R9 nothing after stop", mem[32'h7800 >> 2], pat(32'h7800));
        rd(3, 2, d); check("R9 count frozen after stop", d, 32'h0800);

        @(negedge clk) err_clr = 4'h4;
        @(negedge clk) err_clr = 4'h0;
        check("R10 error cleared", 32'(err_flags), 32'h0);
        check("R10 done held", 32'(done_flags), 32'h3);
        check("R11 irq still high", 32'(irq), 32'h1);
        @(negedge clk) done_clr = 4'h3;
        @(negedge clk) done_clr = 4'h0;
        check("R11 irq low when all clear", 32'({irq, done_flags}), 32'h0);

        wr(2, 3, 32'h8000_0000);
        check("R3 busy follows run", 32'(busy), 32'h4);
        wr(2, 3, 32'h0000_0000);
        check("R3 control write clears run", 32'(busy), 32'h0);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule